// File: doc/BRIEF.md
# Transmit Alarm Indication Signal Controller

This block sits in the transmit path of a primary-rate line framer, just ahead of the line driver. It decides when the outgoing bit stream is replaced by the alarm indication signal (AIS), an unframed stream of continuous ones. It also tells the clocking logic which clock should time the output while the alarm is sent. Software can force AIS directly. The block can also raise AIS on its own when the transmit clock is lost, or when the receive side loses its signal or its clock. For the receive case, the interface-type select decides whether the signal-loss or the clock-loss indication applies.

The loss indications arrive from other clock domains and are synchronized inside the block. The output bit, the active flag and the cause bits all update only on bit boundaries, which are marked by a one-cycle `bitEn` strobe. When line loopback is selected, the block transmits the received bit instead of local data. If automatic AIS is also enabled, a receive loss turns that looped stream into a keep-alive all-ones stream toward the line.

Top module: `txAisCtrl`

## Requirements
- R1: On every bit boundary where AIS is in force, the registered output `dataOut` is 1, whatever the data input holds. Framing positions get no exception.
- R2: If `manualAis` is high at a bit boundary, AIS is active from that boundary on. The active flag and `dataOut`=1 are visible right after that clock edge.
- R3: `clkSelAlt` is 1 exactly when AIS is active and `altClkEn` is 1. Otherwise it is 0, which selects the normal transmit clock.
- R4: With `altClkEn`=1, a high `txLossClk` starts AIS. Through the two-stage synchronizer, AIS becomes active at the third boundary after the input rises (with `bitEn` held high).
- R5: With `autoAisEn`=1 and `digitalIf`=0 (analog interface), `rxLossSig` starts AIS after the same three-boundary delay, and `rxLossClk` has no effect.
- R6: With `autoAisEn`=1 and `digitalIf`=1 (digital interface), `rxLossClk` starts AIS, and `rxLossSig` has no effect.
- R7: While `altClkEn`=0 and `autoAisEn`=0, none of the three loss indications changes `dataOut` or `aisActive`.
- R8: With `lineLoop`=1 and AIS inactive, `dataOut` is the `rxData` bit captured at the boundary. With `lineLoop`=1 and an automatic receive-loss trigger, the output becomes all ones (keep-alive).
- R9: AIS ends on the first bit boundary after every active trigger has cleared. For an automatic trigger, that is the third boundary after its input falls. Without `bitEn`, `dataOut`, `aisActive` and `aisCause` hold their values.
- R10: `aisCause` bit 0 records a manual cause and bit 1 records an automatic cause, both captured on the same boundary. `aisActive` is the OR of the two bits.
- R11: After reset, `dataOut`, `aisActive`, `aisCause` and `clkSelAlt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | One-cycle strobe marking a transmit bit boundary |
| txData | input | 1 | Local serial data bit to transmit |
| rxData | input | 1 | Received bit used when line loopback is on |
| manualAis | input | 1 | Software AIS request |
| altClkEn | input | 1 | Alternate AIS clock enable; also arms the transmit-clock-loss trigger |
| autoAisEn | input | 1 | Enables AIS on receive loss |
| lineLoop | input | 1 | Line loopback: transmit the received bits |
| txLossClk | input | 1 | Transmit loss-of-clock indication (asynchronous) |
| rxLossSig | input | 1 | Receive loss-of-signal indication (asynchronous) |
| rxLossClk | input | 1 | Receive loss-of-clock indication (asynchronous) |
| digitalIf | input | 1 | 1 = digital line interface, 0 = analog |
| dataOut | output | 1 | Transmitted bit |
| aisActive | output | 1 | AIS currently in force |
| aisCause | output | 2 | Bit 0 manual, bit 1 automatic |
| clkSelAlt | output | 1 | 1 = time output from the alternate AIS clock |

## Verification
On every cycle, the assertions check four things: an active alarm always shows as a 1 on the output, the active flag agrees with the cause bits, the alternate clock is never selected outside AIS, and nothing moves between bit boundaries. A manual request reaching the output one boundary later is also checked every cycle. Only the directed scenarios can show the things that depend on delays and on which indication counts:
- the three-boundary latency through the synchronizers;
- the choice between signal loss and clock loss by interface type;
- that indications are ignored when their enable is off;
- the release timing;
- the keep-alive substitution of looped data.

// File: rtl/txAisPkg.sv
package txAisPkg;
  localparam int TRIG_COUNT = 3;
  typedef enum logic [1:0] {TRIG_TXCLK = 2'd0, TRIG_RXSIG = 2'd1, TRIG_RXCLK = 2'd2} trigIdx_e;
  typedef struct packed {
    logic load;       // capture a new output bit this cycle
    logic forceOnes;  // the bit about to be captured is AIS
  } aisStrobe_t;
endpackage

// File: rtl/txAisCtl.sv
module txAisCtl
  import txAisPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       manualAis,
  input  logic       altClkEn,
  input  logic       autoAisEn,
  input  logic       digitalIf,
  input  logic [TRIG_COUNT-1:0] lossRaw,
  output aisStrobe_t strobe,
  output logic       aisActive,
  output logic [1:0] aisCause,
  output logic       clkSelAlt
);
  logic [TRIG_COUNT-1:0] lossSync;
  logic manualQ, autoQ, autoReq, rxLoss;

  genvar gi;
  generate
    for (gi = 0; gi < TRIG_COUNT; gi++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], lossRaw[gi]};
      end
      assign lossSync[gi] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    rxLoss  = digitalIf ? lossSync[TRIG_RXCLK] : lossSync[TRIG_RXSIG];
    autoReq = (altClkEn & lossSync[TRIG_TXCLK]) | (autoAisEn & rxLoss);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      manualQ <= 1'b0;
      autoQ   <= 1'b0;
    end else if (bitEn) begin
      manualQ <= manualAis;
      autoQ   <= autoReq;
    end
  end

  assign strobe.load      = bitEn;
  assign strobe.forceOnes = manualAis | autoReq;
  assign aisActive        = manualQ | autoQ;
  assign aisCause         = {autoQ, manualQ};
  assign clkSelAlt        = aisActive & altClkEn;
endmodule

// File: rtl/txAisPath.sv
module txAisPath
  import txAisPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  aisStrobe_t strobe,
  input  logic       lineLoop,
  input  logic       txData,
  input  logic       rxData,
  output logic       dataOut
);
  logic srcBit;
  assign srcBit = lineLoop ? rxData : txData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataOut <= 1'b0;
    else if (strobe.load) dataOut <= strobe.forceOnes ? 1'b1 : srcBit;
  end
endmodule

// File: rtl/txAisCtrl.sv
module txAisCtrl
  import txAisPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       txData,
  input  logic       rxData,
  input  logic       manualAis,
  input  logic       altClkEn,
  input  logic       autoAisEn,
  input  logic       lineLoop,
  input  logic       txLossClk,
  input  logic       rxLossSig,
  input  logic       rxLossClk,
  input  logic       digitalIf,
  output logic       dataOut,
  output logic       aisActive,
  output logic [1:0] aisCause,
  output logic       clkSelAlt
);
  aisStrobe_t strobe;
  logic [TRIG_COUNT-1:0] lossRaw;

  always_comb begin
    lossRaw = '0;
    lossRaw[TRIG_TXCLK] = txLossClk;
    lossRaw[TRIG_RXSIG] = rxLossSig;
    lossRaw[TRIG_RXCLK] = rxLossClk;
  end

  txAisCtl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .manualAis(manualAis),
    .altClkEn(altClkEn), .autoAisEn(autoAisEn), .digitalIf(digitalIf),
    .lossRaw(lossRaw), .strobe(strobe), .aisActive(aisActive),
    .aisCause(aisCause), .clkSelAlt(clkSelAlt)
  );

  txAisPath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineLoop(lineLoop),
    .txData(txData), .rxData(rxData), .dataOut(dataOut)
  );
endmodule

// File: rtl/txAisCtrlChk.sv
module txAisCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       manualAis,
  input logic       dataOut,
  input logic       aisActive,
  input logic [1:0] aisCause,
  input logic       clkSelAlt
);
  // R1: an active alarm is always seen as a one on the line
  a_r1_ones_out: assert property (@(posedge clk) disable iff (!rstN)
    aisActive |-> dataOut);
  // R2: manual request at a boundary is in force after the edge
  a_r2_manual_take: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && manualAis) |=> (aisActive && aisCause[0] && dataOut));
  // R3: alternate clock only during AIS
  a_r3_alt_only_ais: assert property (@(posedge clk) disable iff (!rstN)
    clkSelAlt |-> aisActive);
  // R9: nothing moves between boundaries
  a_r9_hold_off_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(dataOut) && $stable(aisActive) && $stable(aisCause)));
  // R10: active flag agrees with cause bits
  a_r10_cause_match: assert property (@(posedge clk) disable iff (!rstN)
    aisActive == (aisCause != 2'b00));
endmodule

bind txAisCtrl txAisCtrlChk uChk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .manualAis(manualAis),
  .dataOut(dataOut), .aisActive(aisActive), .aisCause(aisCause),
  .clkSelAlt(clkSelAlt)
);

// File: tb/tb_txAisCtrl.sv
`timescale 1ns/1ps
module tb_txAisCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn, txData, rxData, manualAis, altClkEn, autoAisEn, lineLoop;
  logic txLossClk, rxLossSig, rxLossClk, digitalIf;
  logic dataOut, aisActive, clkSelAlt;
  logic [1:0] aisCause;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  txAisCtrl dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .txData(txData), .rxData(rxData),
    .manualAis(manualAis), .altClkEn(altClkEn), .autoAisEn(autoAisEn),
    .lineLoop(lineLoop), .txLossClk(txLossClk), .rxLossSig(rxLossSig),
    .rxLossClk(rxLossClk), .digitalIf(digitalIf), .dataOut(dataOut),
    .aisActive(aisActive), .aisCause(aisCause), .clkSelAlt(clkSelAlt)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idleAll();
    bitEn = 1'b1; txData = 1'b0; rxData = 1'b0; manualAis = 1'b0;
    altClkEn = 1'b0; autoAisEn = 1'b0; lineLoop = 1'b0; txLossClk = 1'b0;
    rxLossSig = 1'b0; rxLossClk = 1'b0; digitalIf = 1'b0;
    tick(4);
  endtask

  task automatic testReset();
    check("R11 dataOut", dataOut, 0);
    check("R11 aisActive", aisActive, 0);
    check("R11 aisCause", aisCause, 0);
    check("R11 clkSelAlt", clkSelAlt, 0);
  endtask

  task automatic testPassThrough();
    logic [7:0] pat = 8'b1011_0010;
    idleAll();
    for (int i = 0; i < 8; i++) begin
      txData = pat[i];
      tick();
      check("R1 data passes when idle", dataOut, pat[i]);
    end
  endtask

  task automatic testManual();
    idleAll();
    txData = 1'b0; manualAis = 1'b1;
    tick();
    check("R2 manual active", aisActive, 1);
    check("R2 manual ones", dataOut, 1);
    check("R10 manual cause", aisCause, 1);
    check("R3 normal clock", clkSelAlt, 0);
    altClkEn = 1'b1;
    #1 check("R3 alt clock in AIS", clkSelAlt, 1);
    altClkEn = 1'b0;
    manualAis = 1'b0;
    tick();
    check("R9 manual release", aisActive, 0);
    check("R9 data back", dataOut, 0);
  endtask

  task automatic testTxLoss();
    idleAll();
    altClkEn = 1'b1; txLossClk = 1'b1;
    tick(2);
    check("R4 not yet active", aisActive, 0);
    tick();
    check("R4 active on third", aisActive, 1);
    check("R10 auto cause", aisCause, 2);
    check("R3 alt selected", clkSelAlt, 1);
    txLossClk = 1'b0;
    tick(2);
    check("R9 still active", aisActive, 1);
    tick();
    check("R9 released", aisActive, 0);
    check("R3 alt released", clkSelAlt, 0);
  endtask

  task automatic testDisabled();
    idleAll();
    txLossClk = 1'b1; rxLossSig = 1'b1; rxLossClk = 1'b1;
    txData = 1'b0;
    tick(5);
    check("R7 no AIS without enables", aisActive, 0);
    check("R7 data unchanged", dataOut, 0);
  endtask

  task automatic testAnalog();
    idleAll();
    autoAisEn = 1'b1; digitalIf = 1'b0; rxLossClk = 1'b1;
    tick(5);
    check("R5 clock loss ignored analog", aisActive, 0);
    check("R5 data kept", dataOut, 0);
    rxLossSig = 1'b1;
    tick(3);
    check("R5 signal loss starts AIS", aisActive, 1);
    check("R5 ones out", dataOut, 1);
  endtask

  task automatic testDigital();
    idleAll();
    autoAisEn = 1'b1; digitalIf = 1'b1; rxLossSig = 1'b1;
    tick(5);
    check("R6 signal loss ignored digital", aisActive, 0);
    rxLossClk = 1'b1;
    tick(3);
    check("R6 clock loss starts AIS", aisActive, 1);
  endtask

  task automatic testLoopKeepAlive();
    idleAll();
    lineLoop = 1'b1; txData = 1'b1; rxData = 1'b0;
    tick();
    check("R8 looped data out", dataOut, 0);
    rxData = 1'b1; txData = 1'b0;
    tick();
    check("R8 looped data one", dataOut, 1);
    rxData = 1'b0; autoAisEn = 1'b1; rxLossSig = 1'b1;
    tick(3);
    check("R8 keep-alive ones", dataOut, 1);
    check("R8 keep-alive active", aisActive, 1);
  endtask

  task automatic testBoundaryAndBoth();
    idleAll();
    txData = 1'b0;
    bitEn = 1'b0; manualAis = 1'b1;
    tick(3);
    check("R9 no change off boundary", aisActive, 0);
    check("R9 data held off boundary", dataOut, 0);
    bitEn = 1'b1;
    tick();
    check("R2 taken at boundary", aisActive, 1);
    altClkEn = 1'b1; txLossClk = 1'b1;
    tick(3);
    check("R10 both causes", aisCause, 3);
    manualAis = 1'b0;
    tick();
    check("R9 auto keeps AIS", aisActive, 1);
    check("R10 auto only", aisCause, 2);
    txLossClk = 1'b0;
    tick(3);
    check("R9 all cleared", aisActive, 0);
  endtask

  initial begin
    bitEn = 1'b0; txData = 1'b0; rxData = 1'b0; manualAis = 1'b0;
    altClkEn = 1'b0; autoAisEn = 1'b0; lineLoop = 1'b0; txLossClk = 1'b0;
    rxLossSig = 1'b0; rxLossClk = 1'b0; digitalIf = 1'b0;
    tick(3);
    testReset();
    rstN = 1'b1;
    tick();
    testPassThrough();
    testManual();
    testTxLoss();
    testDisabled();
    testAnalog();
    testDigital();
    testLoopKeepAlive();
    testBoundaryAndBoth();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule